// File: doc/BRIEF.md
# Code Read-Out Protection Controller

This block guards the on-chip program store of a small controller core against being read out. It holds the code bytes, a 64-byte obfuscation key table and three lock fuses, all of which sit in a non-volatile model that only a full erase returns to the all-ones state. A single read port serves four kinds of access: a programmer's verify read, a signature read, a table read issued by code running from internal memory, and a table read issued by code running from external memory. One write port programs code bytes, key bytes or lock fuses.

Verify reads never return the plain code byte. The byte is combined with the key entry chosen by the low six address bits through an XNOR, so an unprogrammed key table (all ones) gives the byte back unchanged. The three fuses raise protection in cumulative steps. The first step blocks table reads from external code, freezes the external-access pin at its value during reset, and blocks any further code or key programming. The second step also blocks verify. The third step also forbids execution from external memory. A blocked read returns FFH and raises a flag.

The signature ROM returns fixed identification bytes at three addresses, whatever the protection level.

Top module: `code_guard`

## Requirements
- R1: Erase sets every code byte, every key byte and all three lock bits to ones, which gives protection level 0. This takes effect on the clock edge where erase is high.
- R2: Below level 2, a verify read (rd_kind 00) returns ~(code[addr] ^ key[addr[5:0]]) with rd_blocked low. With an all-ones key entry, the code byte comes back unchanged.
- R3: The lock bits are lock[0]=first fuse, lock[1]=second fuse, lock[2]=third fuse, where 0 means programmed. prot_level decodes them as follows: 111 gives 0, 110 gives 1, 100 gives 2, 000 gives 3. Every other combination gives 3.
- R4: At level 1 or above, an external-code table read (rd_kind 11) returns FFH with rd_blocked high. At level 0 it returns the raw code byte with rd_blocked low.
- R5: At level 1 or above, code writes (wr_tgt 00) and key writes (wr_tgt 01) change nothing. Lock writes (wr_tgt 10, bit chosen by wr_addr[1:0] = 0, 1 or 2; value 3 does nothing) still program the chosen bit to 0.
- R6: At level 0, ea_eff follows ea_pin. At level 1 or above, ea_eff holds the value ea_pin had on the last clock edge with rst_n low.
- R7: At level 2 or above, a verify read returns FFH with rd_blocked high.
- R8: ext_exec_ok is low at level 3 and high otherwise.
- R9: A signature read (rd_kind 01) uses rd_addr[7:0]. Address 30H returns 89H, 31H returns 58H, 60H returns DEV_CODE (FAH to FCH), and any other address returns FFH. The read is never blocked at any level.
- R10: An internal-code table read (rd_kind 10) returns the raw code byte, unencrypted, and is never blocked at any level.
- R11: rd_valid is high for exactly the cycle after each clock edge that sampled rd_en high. rd_data and rd_blocked are valid in that cycle. While rst_n is low, rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read path; ea_pin is sampled while low |
| erase | input | 1 | Full erase of code, key table and lock bits |
| ea_pin | input | 1 | External-access strap level |
| wr_en | input | 1 | Write strobe |
| wr_tgt | input | 2 | Write target: 00 code, 01 key, 10 lock bit, 11 none |
| wr_addr | input | ADDR_W | Code address, key index (low bits) or lock bit number |
| wr_data | input | 8 | Byte to program |
| rd_en | input | 1 | Read strobe |
| rd_kind | input | 2 | 00 verify, 01 signature, 10 internal table, 11 external table |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | Read result valid |
| rd_blocked | output | 1 | Read refused by protection |
| prot_level | output | 2 | Decoded protection level 0 to 3 |
| ea_eff | output | 1 | External-access value in force |
| ext_exec_ok | output | 1 | External execution permitted |

## Verification
A wrong lock bit or a wrong level decode shows up on prot_level, ea_eff and ext_exec_ok in the first cycle after the edge that stored it. It also shows in the blocked flag of the next verify or external table read. A corrupt key entry changes only verify data, and only at addresses whose low six bits select that entry. A corrupt code byte shows on both verify reads and internal table reads one cycle after the read is issued. A write that was accepted when it should have been blocked stays hidden until an internal table read or a verify read of that address. For this reason the bench reads back after every locked write.

// File: rtl/cg_pkg.sv
package cg_pkg;
   typedef enum logic [1:0] {
      RK_VERIFY  = 2'b00,
      RK_SIG     = 2'b01,
      RK_TBL_INT = 2'b10,
      RK_TBL_EXT = 2'b11
   } rd_kind_e;

   typedef enum logic [1:0] {
      WT_CODE = 2'b00,
      WT_KEY  = 2'b01,
      WT_LOCK = 2'b10,
      WT_NONE = 2'b11
   } wr_tgt_e;

   typedef enum logic [1:0] {
      PL_OPEN        = 2'd0,
      PL_NO_EXT_TBL  = 2'd1,
      PL_NO_VERIFY   = 2'd2,
      PL_NO_EXT_EXEC = 2'd3
   } prot_lvl_e;

   localparam logic [7:0] BLOCK_FILL = 8'hFF;
   localparam int         LOCK_BITS  = 3;
endpackage

// File: rtl/cg_lock_decode.sv
module cg_lock_decode
   import cg_pkg::*;
#(
   parameter bit UNDEF_AS_MAX = 1'b1
) (
   input  logic [LOCK_BITS-1:0] lock,
   output prot_lvl_e            level
);
   generate
      if (UNDEF_AS_MAX) begin : g_strict
         always_comb begin
            unique case (lock)
               3'b111:  level = PL_OPEN;
               3'b110:  level = PL_NO_EXT_TBL;
               3'b100:  level = PL_NO_VERIFY;
               default: level = PL_NO_EXT_EXEC;
            endcase
         end
      end else begin : g_count
         logic [1:0] n_prog;
         always_comb begin
            n_prog = 2'd0;
            for (int i = 0; i < LOCK_BITS; i++)
               n_prog = n_prog + {1'b0, ~lock[i]};
            level = prot_lvl_e'(n_prog);
         end
      end
   endgenerate
endmodule

// File: rtl/cg_nv_store.sv
module cg_nv_store
   import cg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int KEY_DEPTH = 64
) (
   input  logic                 clk,
   input  logic                 erase,
   input  logic                 code_we,
   input  logic                 key_we,
   input  logic                 lock_we,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [7:0]           wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [7:0]           code_rd,
   output logic [7:0]           key_rd,
   output logic [LOCK_BITS-1:0] lock_q
);
   localparam int CODE_DEPTH = 1 << ADDR_W;
   localparam int KEY_IDX_W  = $clog2(KEY_DEPTH);

   logic [7:0] code_mem [CODE_DEPTH];
   logic [7:0] key_mem  [KEY_DEPTH];

   always_ff @(posedge clk) begin
      if (erase) begin
         for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= 8'hFF;
         for (int k = 0; k < KEY_DEPTH; k++)  key_mem[k]  <= 8'hFF;
         lock_q <= '1;
      end else begin
         if (code_we) code_mem[wr_addr] <= wr_data;
         if (key_we)  key_mem[wr_addr[KEY_IDX_W-1:0]] <= wr_data;
         if (lock_we) begin
            case (wr_addr[1:0])
               2'd0:    lock_q[0] <= 1'b0;
               2'd1:    lock_q[1] <= 1'b0;
               2'd2:    lock_q[2] <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   assign code_rd = code_mem[rd_addr];
   assign key_rd  = key_mem[rd_addr[KEY_IDX_W-1:0]];
endmodule

// File: rtl/cg_sig_rom.sv
module cg_sig_rom #(
   parameter logic [7:0] DEV_CODE = 8'hFC
) (
   input  logic [7:0] addr,
   output logic [7:0] data
);
   always_comb begin
      case (addr)
         8'h30:   data = 8'h89;
         8'h31:   data = 8'h58;
         8'h60:   data = DEV_CODE;
         default: data = 8'hFF;
      endcase
   end
endmodule

// File: rtl/code_guard.sv
module code_guard
   import cg_pkg::*;
#(
   parameter int         ADDR_W       = 8,
   parameter int         KEY_DEPTH    = 64,
   parameter logic [7:0] DEV_CODE     = 8'hFC,
   parameter bit         UNDEF_AS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              ea_pin,
   input  logic              wr_en,
   input  logic [1:0]        wr_tgt,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [1:0]        rd_kind,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              rd_blocked,
   output logic [1:0]        prot_level,
   output logic              ea_eff,
   output logic              ext_exec_ok
);
   localparam int KEY_IDX_W = $clog2(KEY_DEPTH);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("code_guard: ADDR_W must be at least 8");
      end
      if (KEY_DEPTH != (1 << KEY_IDX_W) || KEY_DEPTH > (1 << ADDR_W)) begin : g_bad_key
         $error("code_guard: KEY_DEPTH must be a power of two not above the code depth");
      end
      if (DEV_CODE < 8'hFA || DEV_CODE > 8'hFC) begin : g_bad_dev
         $error("code_guard: DEV_CODE out of range");
      end
   endgenerate

   prot_lvl_e            lvl;
   logic [LOCK_BITS-1:0] lock_q;
   logic [7:0]           code_rd, key_rd, sig_rd;
   logic                 lvl_ge1, lvl_ge2;
   logic                 code_we, key_we, lock_we;
   logic                 ea_lat;
   logic [7:0]           rd_mux;
   logic                 blk_mux;
   wr_tgt_e              tgt;
   rd_kind_e             kind;

   assign tgt  = wr_tgt_e'(wr_tgt);
   assign kind = rd_kind_e'(rd_kind);

   cg_lock_decode #(.UNDEF_AS_MAX(UNDEF_AS_MAX)) u_dec (
      .lock (lock_q),
      .level(lvl)
   );

   assign lvl_ge1 = (lvl != PL_OPEN);
   assign lvl_ge2 = (lvl == PL_NO_VERIFY) || (lvl == PL_NO_EXT_EXEC);

   assign code_we = wr_en && (tgt == WT_CODE) && !lvl_ge1;
   assign key_we  = wr_en && (tgt == WT_KEY)  && !lvl_ge1;
   assign lock_we = wr_en && (tgt == WT_LOCK);

   cg_nv_store #(.ADDR_W(ADDR_W), .KEY_DEPTH(KEY_DEPTH)) u_nv (
      .clk    (clk),
      .erase  (erase),
      .code_we(code_we),
      .key_we (key_we),
      .lock_we(lock_we),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .code_rd(code_rd),
      .key_rd (key_rd),
      .lock_q (lock_q)
   );

   cg_sig_rom #(.DEV_CODE(DEV_CODE)) u_sig (
      .addr(rd_addr[7:0]),
      .data(sig_rd)
   );

   always_comb begin
      blk_mux = 1'b0;
      rd_mux  = code_rd;
      unique case (kind)
         RK_VERIFY: begin
            blk_mux = lvl_ge2;
            rd_mux  = lvl_ge2 ? BLOCK_FILL : ~(code_rd ^ key_rd);
         end
         RK_SIG:     rd_mux = sig_rd;
         RK_TBL_INT: rd_mux = code_rd;
         RK_TBL_EXT: begin
            blk_mux = lvl_ge1;
            rd_mux  = lvl_ge1 ? BLOCK_FILL : code_rd;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_blocked <= 1'b0;
         rd_data    <= 8'h00;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_blocked <= blk_mux;
            rd_data    <= rd_mux;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ea_lat <= ea_pin;
   end

   assign ea_eff      = lvl_ge1 ? ea_lat : ea_pin;
   assign ext_exec_ok = (lvl != PL_NO_EXT_EXEC);
   assign prot_level  = lvl;

   a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   a_r1_erase_opens: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (prot_level == 2'd0));
   a_r7_verify_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_kind == 2'b00 && !lock_q[0] && !lock_q[1]) |=> (rd_blocked && rd_data == 8'hFF));
   a_r4_ext_tbl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_kind == 2'b11 && !lock_q[0]) |=> rd_blocked);
   a_r10_int_tbl_open: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_kind == 2'b10) |=> !rd_blocked);
   a_r9_sig_open: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_kind == 2'b01) |=> !rd_blocked);
   a_r8_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q == 3'b000) |-> !ext_exec_ok);
   a_r6_ea_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_level != 2'd0 && !erase) |=> $stable(ea_eff));
endmodule

// File: tb/code_guard_test.sv
module code_guard_test;
   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n, erase, ea_pin, wr_en, rd_en;
   logic [1:0]        wr_tgt, rd_kind;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [7:0]        wr_data, rd_data;
   logic              rd_valid, rd_blocked, ea_eff, ext_exec_ok;
   logic [1:0]        prot_level;

   code_guard uut (
      .clk(clk), .rst_n(rst_n), .erase(erase), .ea_pin(ea_pin),
      .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_kind(rd_kind), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_blocked(rd_blocked),
      .prot_level(prot_level), .ea_eff(ea_eff), .ext_exec_ok(ext_exec_ok)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [7:0] code_m [256];
   logic [7:0] key_m  [64];
   logic [2:0] lock_m;
   logic       ea_lat_m;

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h exp %0h", req, act, exp);
      end
   endtask

   function automatic int lvl_m();
      case (lock_m)
         3'b111:  return 0;
         3'b110:  return 1;
         3'b100:  return 2;
         default: return 3;
      endcase
   endfunction

   function automatic logic [7:0] sig_m(input logic [7:0] a);
      case (a)
         8'h30:   return 8'h89;
         8'h31:   return 8'h58;
         8'h60:   return 8'hFC;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic model_erase();
      for (int i = 0; i < 256; i++) code_m[i] = 8'hFF;
      for (int i = 0; i < 64; i++)  key_m[i]  = 8'hFF;
      lock_m = 3'b111;
   endtask

   task automatic check_status(input logic exp_valid);
      chk("R3 level", 32'(prot_level), 32'(lvl_m()));
      chk("R6 ea_eff", 32'(ea_eff), 32'(lvl_m() >= 1 ? ea_lat_m : ea_pin));
      chk("R8 exec", 32'(ext_exec_ok), 32'(lvl_m() != 3));
      chk("R11 valid", 32'(rd_valid), 32'(exp_valid));
   endtask

   task automatic do_reset(input logic pin, input logic with_erase);
      rst_n = 1'b0; ea_pin = pin; erase = with_erase;
      @(negedge clk);
      erase = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      ea_lat_m = pin;
      if (with_erase) model_erase();
   endtask

   task automatic do_erase();
      erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
      model_erase();
      check_status(1'b0);
   endtask

   task automatic do_write(input logic [1:0] t, input logic [7:0] a, input logic [7:0] d);
      int lv;
      lv = lvl_m();
      wr_en = 1'b1; wr_tgt = t; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (t == 2'b00 && lv == 0) code_m[a] = d;
      if (t == 2'b01 && lv == 0) key_m[a[5:0]] = d;
      if (t == 2'b10 && a[1:0] != 2'b11) lock_m[a[1:0]] = 1'b0;
      check_status(1'b0);
   endtask

   task automatic do_read(input logic [1:0] k, input logic [7:0] a);
      logic [7:0] ed;
      logic       eb;
      string      tag;
      int         lv;
      lv = lvl_m();
      eb = 1'b0;
      case (k)
         2'b00: begin
            tag = (lv >= 2) ? "R7 verify" : "R2 verify";
            eb  = (lv >= 2);
            ed  = eb ? 8'hFF : ~(code_m[a] ^ key_m[a[5:0]]);
         end
         2'b01: begin tag = "R9 signature"; ed = sig_m(a); end
         2'b10: begin tag = "R10 int table"; ed = code_m[a]; end
         default: begin
            tag = "R4 ext table";
            eb  = (lv >= 1);
            ed  = eb ? 8'hFF : code_m[a];
         end
      endcase
      rd_en = 1'b1; rd_kind = k; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk(tag, 32'(rd_data), 32'(ed));
      chk({tag, " blocked"}, 32'(rd_blocked), 32'(eb));
      check_status(1'b1);
   endtask

   initial begin
      rst_n = 1'b0; erase = 1'b0; ea_pin = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      wr_tgt = 2'b11; rd_kind = 2'b00; wr_addr = '0; rd_addr = '0; wr_data = '0;
      lock_m = 3'b111; ea_lat_m = 1'b0;
      void'($urandom(32'h5EED_C0DE));
      @(negedge clk);
      do_reset(1'b1, 1'b1);
      @(negedge clk);
      // R1 R11: reset and erased state
      check_status(1'b0);
      do_read(2'b10, 8'h44);
      // R2: all-ones key passes code, programmed key XNORs
      do_write(2'b00, 8'h10, 8'h5A);
      do_read(2'b00, 8'h10);
      do_write(2'b01, 8'h10, 8'h0F);
      do_read(2'b00, 8'h10);
      do_read(2'b00, 8'h50);
      // R9 signature
      do_read(2'b01, 8'h30);
      do_read(2'b01, 8'h31);
      do_read(2'b01, 8'h60);
      do_read(2'b01, 8'h61);
      // R4 R5 R6: first fuse
      ea_pin = 1'b0;
      do_write(2'b10, 8'h00, 8'h00);
      do_read(2'b11, 8'h10);
      do_read(2'b10, 8'h10);
      do_write(2'b00, 8'h10, 8'h33);
      do_write(2'b01, 8'h10, 8'h33);
      do_read(2'b10, 8'h10);
      do_read(2'b00, 8'h10);
      // R7 R8: second and third fuses
      do_write(2'b10, 8'h01, 8'h00);
      do_read(2'b00, 8'h10);
      do_write(2'b10, 8'h02, 8'h00);
      do_read(2'b01, 8'h60);
      // R1 erase restores
      do_erase();
      do_read(2'b00, 8'h10);
      do_read(2'b10, 8'h10);
      // R3 undefined combination: second fuse alone
      do_write(2'b10, 8'h01, 8'h00);
      do_read(2'b00, 8'h20);
      do_erase();
      // random phase
      for (int it = 0; it < 4000; it++) begin
         int r;
         r = $urandom_range(0, 99);
         ea_pin = 1'($urandom());
         if (r < 2) begin
            do_reset(1'($urandom()), 1'b0);
            @(negedge clk);
            check_status(1'b0);
         end else if (r < 5) begin
            do_erase();
         end else if (r < 8) begin
            do_write(2'b10, 8'($urandom_range(0, 3)), 8'h00);
         end else if (r < 35) begin
            do_write(2'($urandom_range(0, 1)), 8'($urandom()), 8'($urandom()));
         end else begin
            logic [7:0] a;
            int s;
            s = $urandom_range(0, 5);
            a = (s == 0) ? 8'h30 : (s == 1) ? 8'h31 : (s == 2) ? 8'h60 : 8'($urandom());
            do_read(2'($urandom()), a);
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule